// File: doc/BRIEF.md
# Timed Host Controller for an Edge-Latched-Address SRAM

This block sits between a synchronous host and an external static RAM that captures its address on the falling edge of an active-low chip enable. The host raises a request with a read/write flag, an 11-bit address and, for writes, a byte of data, and holds it until the controller returns a one-clock acknowledge. The controller latches the request and then drives the memory's address, chip enable, write enable, output enable and write-data lines. Each edge is placed a whole number of clock cycles apart, so that every minimum interval the memory needs is met.

All memory timing limits are parameters in nanoseconds. The block converts each one to clock cycles by rounding up against a clock-period parameter. From these it derives one low-window length for chip enable, one recovery length and one write-data hold length. Read data is sampled on the last cycle of the low window and is presented to the host together with the acknowledge.

Top module: `lasram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, memCeN, memWeN and memOeN are 1, memWdEn and ack are 0, and rdData is 0.
- R2: The memory address is loaded from reqAddr one clock before memCeN falls and is unchanged from that cycle until memCeN rises. Changes on reqAddr or reqWData after the request is taken do not reach the memory.
- R3: memCeN stays low for at least ceil(120 ns / clock period) cycles per access.
- R4: Between accesses memCeN stays high for at least ceil(50 ns / period) cycles, and consecutive memCeN falls are at least ceil(170 ns / period) cycles apart. A request that arrives sooner waits with ack low.
- R5: On a write (reqWrite = 1), memWeN falls with memCeN and rises no earlier than memCeN, stays low for at least ceil(120 ns / period) cycles, is never low while memCeN is high, and memOeN stays 1 for the whole write.
- R6: On a write, memWdEn is 1 and memWData is constant from before memCeN falls until at least ceil(10 ns / period) cycles after the edge that ends the write.
- R7: On a read (reqWrite = 0), memOeN falls with memCeN while memWeN stays 1. rdData takes memRData as sampled on the last cycle memCeN is low, which is at least ceil(120 ns / period) cycles after the chip-enable fall and ceil(80 ns / period) cycles after the output-enable fall.
- R8: ack is a single-cycle pulse, one per access, and rises on the same clock as memCeN. A request still held high during the acknowledge cycle does not start a second access.
- R9: A write stores reqWData at reqAddr in the memory, and a later read of that address returns the most recently written byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request, held until ack |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 11 | Host address |
| reqWData | input | 8 | Host write data |
| ack | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Read data, valid with ack on reads |
| memAddr | output | 11 | Address to the memory |
| memCeN | output | 1 | Active-low chip enable |
| memWeN | output | 1 | Active-low write enable |
| memOeN | output | 1 | Active-low output enable |
| memWdEn | output | 1 | Write-data drive enable for the shared data lines |
| memWData | output | 8 | Write data to the memory |
| memRData | input | 8 | Data read from the memory |

## Verification
Several properties are checked on every clock cycle: that the address stays stable across chip-enable low, the minimum low, high and write-enable widths (measured with run counters), that output enable stays off while write enable is low, that write data is driven through the write and its hold, and that ack is a single-cycle pulse that coincides with chip enable rising. Other behaviour only the scenarios can show. The memory model returns a marker value until the access time has elapsed, so a read that samples too early gets the marker. Round trips with overwrites at both ends of the address range show that data arrives at the latched address, and changing the host inputs in mid-access shows they do not leak through. Counting chip-enable falls against issued requests shows that a request held through the acknowledge is not taken twice.

// File: rtl/lasram_pkg.sv
package lasram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HOLD
  } seqState_t;

  typedef struct packed {
    logic load;     // latch host address, data and direction
    logic capture;  // sample memory read data into the host register
  } pathStrobe_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lasram_seq.sv
module lasram_seq
  import lasram_pkg::*;
#(
  parameter int LOW_C    = 6,
  parameter int REC_LOAD = 1,
  parameter int HOLD_C   = 1,
  parameter int CNT_W    = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        ack,
  output logic        memCeN,
  output logic        memWeN,
  output logic        memOeN,
  output logic        memWdEn,
  output pathStrobe_t strobe
);

  localparam logic [CNT_W-1:0] LOW_LOAD  = CNT_W'(LOW_C - 1);
  localparam logic [CNT_W-1:0] REC_VAL   = CNT_W'(REC_LOAD);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'((HOLD_C > 0) ? HOLD_C - 1 : 0);
  localparam bit               HAS_HOLD  = (HOLD_C > 0);

  seqState_t        state;
  logic             isWrite;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] recCnt;
  logic             accept;
  logic             lastLow;

  // Recovery done, no acknowledge in flight: a held request is not retaken
  assign accept  = (state == ST_IDLE) && reqValid && (recCnt == '0) && !ack;
  assign lastLow = (state == ST_LOW) && (phaseCnt == '0);

  always_comb begin
    strobe.load    = accept;
    strobe.capture = lastLow && !isWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      isWrite  <= 1'b0;
      phaseCnt <= '0;
      recCnt   <= '0;
      memCeN   <= 1'b1;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      memWdEn  <= 1'b0;
      ack      <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (recCnt != '0) recCnt <= recCnt - 1'b1;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            isWrite <= reqWrite;
            memWdEn <= reqWrite;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          memCeN   <= 1'b0;
          memWeN   <= !isWrite;
          memOeN   <= isWrite;
          phaseCnt <= LOW_LOAD;
          state    <= ST_LOW;
        end
        ST_LOW: begin
          if (lastLow) begin
            memCeN <= 1'b1;
            memWeN <= 1'b1;
            memOeN <= 1'b1;
            ack    <= 1'b1;
            recCnt <= REC_VAL;
            if (isWrite && HAS_HOLD) begin
              phaseCnt <= HOLD_LOAD;
              state    <= ST_HOLD;
            end else begin
              memWdEn <= 1'b0;
              state   <= ST_IDLE;
            end
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (phaseCnt == '0) begin
            memWdEn <= 1'b0;
            state   <= ST_IDLE;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lasram_path.sv
module lasram_path
  import lasram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [DATA_W-1:0] rdData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memWData <= '0;
      rdData   <= '0;
    end else begin
      if (strobe.load) begin
        memAddr  <= reqAddr;
        memWData <= reqWData;
      end
      if (strobe.capture) rdData <= memRData;
    end
  end

endmodule

// File: rtl/lasram_ctrl.sv
module lasram_ctrl
  import lasram_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 20,
  parameter int ADDR_HOLD_NS = 30,
  parameter int CE_LOW_NS    = 120,
  parameter int CE_HIGH_NS   = 50,
  parameter int CYCLE_NS     = 170,
  parameter int WSETUP_NS    = 50,
  parameter int WHOLD_NS     = 10,
  parameter int WE_LOW_NS    = 120,
  parameter int RD_CE_NS     = 120,
  parameter int RD_OE_NS     = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  output logic              ack,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memWdEn,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData
);

  localparam int ADDR_HOLD_C = nsToCycles(ADDR_HOLD_NS, CLK_NS);
  localparam int CE_LOW_C    = nsToCycles(CE_LOW_NS, CLK_NS);
  localparam int CE_HIGH_C   = nsToCycles(CE_HIGH_NS, CLK_NS);
  localparam int CYCLE_C     = nsToCycles(CYCLE_NS, CLK_NS);
  localparam int WSETUP_C    = nsToCycles(WSETUP_NS, CLK_NS);
  localparam int WHOLD_C     = nsToCycles(WHOLD_NS, CLK_NS);
  localparam int WE_LOW_C    = nsToCycles(WE_LOW_NS, CLK_NS);
  localparam int RD_CE_C     = nsToCycles(RD_CE_NS, CLK_NS);
  localparam int RD_OE_C     = nsToCycles(RD_OE_NS, CLK_NS);

  // Write data is valid one cycle before the fall, so setup needs one less
  localparam int LOW_C = maxOf(
                           maxOf(maxOf(CE_LOW_C, ADDR_HOLD_C), maxOf(WE_LOW_C, RD_CE_C)),
                           maxOf(maxOf(RD_OE_C, CYCLE_C - CE_HIGH_C), maxOf(WSETUP_C - 1, 1)));
  localparam int HIGH_C   = maxOf(CE_HIGH_C, CYCLE_C - LOW_C);
  // Accept and setup cycles add two high cycles after the counter expires
  localparam int REC_LOAD = maxOf(HIGH_C - 2, 0);
  localparam int CNT_W    = maxOf($clog2(maxOf(maxOf(LOW_C, REC_LOAD), WHOLD_C) + 1), 1);

  pathStrobe_t strobe;

  lasram_seq #(
    .LOW_C   (LOW_C),
    .REC_LOAD(REC_LOAD),
    .HOLD_C  (WHOLD_C),
    .CNT_W   (CNT_W)
  ) seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .ack     (ack),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memWdEn (memWdEn),
    .strobe  (strobe)
  );

  lasram_path #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWData(reqWData),
    .memRData(memRData),
    .memAddr (memAddr),
    .memWData(memWData),
    .rdData  (rdData)
  );

endmodule

// File: rtl/lasram_ctrl_chk.sv
module lasram_ctrl_chk
  import lasram_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int CLK_NS     = 20,
  parameter int CE_LOW_NS  = 120,
  parameter int CE_HIGH_NS = 50,
  parameter int WE_LOW_NS  = 120,
  parameter int WHOLD_NS   = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              ack,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memWdEn
);

  localparam logic [15:0] LOW_MIN  = 16'(nsToCycles(CE_LOW_NS, CLK_NS));
  localparam logic [15:0] HIGH_MIN = 16'(nsToCycles(CE_HIGH_NS, CLK_NS));
  localparam logic [15:0] WE_MIN   = 16'(nsToCycles(WE_LOW_NS, CLK_NS));
  localparam bit          HOLD_ON  = (nsToCycles(WHOLD_NS, CLK_NS) > 0);

  logic [15:0] lowRun, highRun, weRun;

  // Run lengths in sampled cycles; chip enable counts as long-high out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= '1;
      weRun   <= '0;
    end else begin
      lowRun  <= memCeN ? '0 : ((lowRun == '1) ? lowRun : lowRun + 1'b1);
      highRun <= !memCeN ? '0 : ((highRun == '1) ? highRun : highRun + 1'b1);
      weRun   <= memWeN ? '0 : ((weRun == '1) ? weRun : weRun + 1'b1);
    end
  end

  AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCeN) |-> $stable(memAddr)); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !$fell(memCeN)) |-> $stable(memAddr)); // R2
  AST_CE_LOW_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |-> (lowRun >= LOW_MIN)); // R3
  AST_CE_HIGH_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCeN) |-> (highRun >= HIGH_MIN)); // R4
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN); // R5
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN); // R5
  AST_WE_LOW_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weRun >= WE_MIN)); // R5
  AST_WD_DURING_WE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memWdEn); // R6
  AST_WD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (HOLD_ON && $rose(memCeN) && $past(!memWeN)) |-> memWdEn); // R6
  AST_RD_OE_WITH_CE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memCeN) && memWeN) |-> !memOeN); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack); // R8
  AST_ACK_WITH_CE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> $rose(memCeN)); // R8

endmodule

bind lasram_ctrl lasram_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .CLK_NS    (CLK_NS),
  .CE_LOW_NS (CE_LOW_NS),
  .CE_HIGH_NS(CE_HIGH_NS),
  .WE_LOW_NS (WE_LOW_NS),
  .WHOLD_NS  (WHOLD_NS)
) chk (
  .clk    (clk),
  .rstN   (rstN),
  .ack    (ack),
  .memAddr(memAddr),
  .memCeN (memCeN),
  .memWeN (memWeN),
  .memOeN (memOeN),
  .memWdEn(memWdEn)
);

// File: tb/lasram_ctrl_test.sv
module lasram_ctrl_test;

  localparam int PER     = 20;
  localparam int B_LOW   = (120 + PER - 1) / PER;
  localparam int B_HIGH  = (50 + PER - 1) / PER;
  localparam int B_CYC   = (170 + PER - 1) / PER;
  localparam int B_WE    = (120 + PER - 1) / PER;
  localparam int B_RDCE  = (120 + PER - 1) / PER;
  localparam int B_RDOE  = (80 + PER - 1) / PER;
  localparam int WATCHDOG = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [10:0] reqAddr = '0;
  logic [7:0]  reqWData = '0;
  logic        ack;
  logic [7:0]  rdData;
  logic [10:0] memAddr;
  logic        memCeN, memWeN, memOeN, memWdEn;
  logic [7:0]  memWData;
  logic [7:0]  memRData;

  always #10 clk = ~clk;

  lasram_ctrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWData(reqWData), .ack(ack), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memWdEn(memWdEn), .memWData(memWData), .memRData(memRData)
  );

  int checks = 0;
  int fails  = 0;
  int issued = 0;
  int ceFalls = 0;
  int cycles = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp, input bit ok);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0]  modelMem [0:2047];
  logic [10:0] latAddr = '0;
  int          ceCnt = 0, oeCnt = 0;
  assign memRData = (!memCeN && !memOeN && ceCnt >= B_RDCE && oeCnt >= B_RDOE)
                    ? modelMem[latAddr] : 8'hEE;

  // timing monitor state
  bit          prevCe = 1'b1;
  bit          seenAccess = 1'b0;
  int          sinceFall = 0, lowCnt = 0, highCnt = 0, weCnt = 0;
  bit          addrMoved, oeBad, wdBad, isRd, rdOeOk;
  logic [7:0]  wdRef;

  always @(negedge clk) begin
    if (rstN) begin
      sinceFall++;
      if (!memCeN && prevCe) begin
        ceFalls++;
        if (seenAccess) begin
          check("R4", "chip enable high cycles", highCnt, B_HIGH, highCnt >= B_HIGH);
          check("R4", "fall to fall cycles", sinceFall, B_CYC, sinceFall >= B_CYC);
        end
        seenAccess = 1'b1;
        latAddr = memAddr;
        wdRef = memWData;
        isRd = memWeN;
        rdOeOk = !memOeN;
        addrMoved = 0; oeBad = 0; wdBad = 0;
        sinceFall = 0; lowCnt = 0; highCnt = 0; weCnt = 0;
      end
      if (!memCeN) begin
        lowCnt++;
        ceCnt++;
        if (!memOeN) oeCnt++; else oeCnt = 0;
        if (memAddr != latAddr) addrMoved = 1;
        if (!memWeN) begin
          weCnt++;
          if (!memOeN) oeBad = 1;
          if (!memWdEn || memWData != wdRef) wdBad = 1;
          modelMem[latAddr] = memWData;
        end
      end else begin
        ceCnt = 0;
        oeCnt = 0;
        highCnt++;
        if (!prevCe) begin
          check("R3", "chip enable low cycles", lowCnt, B_LOW, lowCnt >= B_LOW);
          check("R2", "address moved while enabled", int'(addrMoved), 0, !addrMoved);
          if (isRd) begin
            check("R7", "output enable fell with chip enable", int'(rdOeOk), 1, rdOeOk);
          end else begin
            check("R5", "write enable low cycles", weCnt, B_WE, weCnt >= B_WE);
            check("R5", "output enable low during write", int'(oeBad), 0, !oeBad);
            check("R6", "write data held after end edge", int'(wdBad || !memWdEn || memWData != wdRef), 0,
                  !wdBad && memWdEn && memWData == wdRef);
          end
        end
      end
      prevCe = memCeN;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit wr; logic [10:0] a; logic [7:0] d; } item_t;
  item_t       expQ[$];
  logic [7:0]  shadow [0:2047];
  bit          prevAck = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (ack && prevAck) check("R8", "ack longer than one cycle", 2, 1, 1'b0);
      if (ack) begin
        if (expQ.size() == 0) begin
          check("R8", "ack without request", 1, 0, 1'b0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          if (it.wr) check("R9", "byte stored at address", int'(modelMem[it.a]), int'(it.d), modelMem[it.a] === it.d);
          else       check("R7", "read data", int'(rdData), int'(it.d), rdData === it.d);
        end
      end
      prevAck = ack;
    end
  end

  task automatic doAccess(input bit wr, input logic [10:0] a, input logic [7:0] d);
    item_t it;
    it.wr = wr;
    it.a  = a;
    it.d  = wr ? d : shadow[a];
    if (wr) shadow[a] = d;
    expQ.push_back(it);
    issued++;
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = a;
    reqWData = d;
    do begin
      @(negedge clk);
      // once the access has started, the host inputs must no longer matter (R2)
      if (!memCeN) begin
        reqAddr  = ~a;
        reqWData = ~d;
      end
    end while (!ack);
    // keep the request up through the acknowledge edge (R8)
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R8 watchdog: actual=%0d cycles expected=under %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin
      modelMem[i] = 8'h00;
      shadow[i]   = 8'h00;
    end
    repeat (3) @(negedge clk);
    check("R1", "reset outputs", int'({memCeN, memWeN, memOeN, memWdEn, ack}), 5'b11100,
          {memCeN, memWeN, memOeN, memWdEn, ack} == 5'b11100 && rdData == 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "outputs after reset release", int'({memCeN, memWeN, memOeN, memWdEn, ack}), 5'b11100,
          {memCeN, memWeN, memOeN, memWdEn, ack} == 5'b11100);

    doAccess(1'b1, 11'h000, 8'h5A);
    doAccess(1'b1, 11'h7FF, 8'hA5);
    doAccess(1'b1, 11'h123, 8'h3C);
    doAccess(1'b0, 11'h000, 8'h00);
    doAccess(1'b0, 11'h7FF, 8'h00);
    doAccess(1'b0, 11'h123, 8'h00);
    doAccess(1'b1, 11'h123, 8'hC3);
    doAccess(1'b0, 11'h123, 8'h00);
    for (int i = 0; i < 8; i++) doAccess(1'b1, 11'(i * 97 + 5), 8'(i * 29 + 1));
    for (int i = 7; i >= 0; i--) doAccess(1'b0, 11'(i * 97 + 5), 8'h00);
    doAccess(1'b0, 11'h000, 8'h00);

    repeat (10) @(negedge clk);
    check("R8", "one chip-enable fall per request", ceFalls, issued, ceFalls == issued);
    check("R8", "all acknowledges seen", expQ.size(), 0, expQ.size() == 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule